// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch and Single-Level Return

This block produces the microcode address for a microprogrammed processor. It holds an 11-bit location counter. On every enabled cycle the counter moves to a new value. It can advance by one, take an immediate jump target, call a subroutine, return from one, or dispatch through an opcode translation table. A single return register remembers where a called routine resumes. Nested calls are not supported in hardware.

The counter addresses a control store made of 512-word banks holding 22-bit microwords. The upper address bits pick the bank, and a parameter mask says which of up to three banks are fitted. Reading an unfitted bank yields a zero microword and raises a missing-bank flag. A pending interrupt, tested by the current microword, forces the next address to a fixed service entry.

Top module: `useq_top`

## Requirements
- R1: While reset is held, and on the first enabled cycle after it, the location counter reads 0x000. The return register reads 0x000, so a return issued straight after reset lands on 0x000.
- R2: With `step` high and `seq_op` = 0 (increment), the counter becomes counter+1 modulo 2048, so 0x7FF wraps to 0x000. The unused codes 5, 6 and 7 behave the same as increment.
- R3: With `step` high and `seq_op` = 1 (jump), the counter takes `jmp_tgt` on the next clock edge.
- R4: With `step` high and `seq_op` = 2 (call), the counter takes `jmp_tgt`, and the return register takes the old counter+1 modulo 2048.
- R5: With `step` high and `seq_op` = 3 (return), the counter takes the return register. Only a call writes the return register.
- R6: With `step` high and `seq_op` = 4 (dispatch), the counter takes the target of the lowest-numbered matching table entry. An entry matches when (opcode & mask) == match. The default entries are: e0 mask 0xFFFF, match 0x0000, target 0x040; e1 mask 0xFFC0, match 0x0A00, target 0x080; e2 mask 0xF000, match 0x1000, target 0x0C0; e3 mask 0xFF00, match 0x0A00, target 0x100. When no entry matches, the counter takes 0x7F0.
- R7: With `step` high, `int_pend` high and `int_test` high, the counter takes 0x010 whatever `seq_op` is. The return register is left unchanged. If either `int_pend` or `int_test` is low, the interrupt has no effect.
- R8: The bank index is address bits [10:9]. For a fitted bank, `uword` = {address, ~address}. Bank 3 is never fitted. For an unfitted bank, `uword` is 0 and `bank_missing` is 1; otherwise `bank_missing` is 0.
- R9: With `step` low, neither the counter nor the return register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step | input | 1 | Clock enable for the sequencer |
| seq_op | input | 3 | Next-address select: 0 inc, 1 jump, 2 call, 3 return, 4 dispatch |
| jmp_tgt | input | 11 | Immediate target for jump and call |
| int_pend | input | 1 | Interrupt pending |
| int_test | input | 1 | Interrupt-test bit of the current microword |
| opcode | input | 16 | Fetched macro-instruction for dispatch |
| uaddr | output | 11 | Location counter |
| uword | output | 22 | Microword read from the control store |
| bank_missing | output | 1 | Current address falls in an unfitted bank |

## Verification
The bench builds the block with the bank mask set to 3'b101. Bank 1 is then absent while bank 2 is fitted, so the zero-word path and the fitted path are both covered on either side of the bank that exists by default. With that setting, a jump sweep over all 2048 addresses checks every microword and missing-bank flag. A dispatch sweep over all 65536 opcodes checks the table priority, including the overlap of entries e1 and e3 and the illegal-instruction fallback. Directed sequences then cover counter wrap, calls at 0x7FF, an interrupt arriving during a call, and held cycles.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    SEQ_INC  = 3'd0,
    SEQ_JMP  = 3'd1,
    SEQ_CALL = 3'd2,
    SEQ_RET  = 3'd3,
    SEQ_DISP = 3'd4
  } seq_op_e;
endpackage

// File: rtl/useq_xlate.sv
module useq_xlate #(
  parameter int AW   = 11,
  parameter int OPW  = 16,
  parameter int NENT = 4,
  parameter logic [NENT*OPW-1:0] XL_MASK  = '0,
  parameter logic [NENT*OPW-1:0] XL_MATCH = '0,
  parameter logic [NENT*AW-1:0]  XL_TGT   = '0,
  parameter logic [AW-1:0]       ILL_ADDR = '0
) (
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  disp_addr
);
  logic [NENT-1:0] hit;

  // one comparator per table entry
  for (genvar e = 0; e < NENT; e++) begin : g_ent
    assign hit[e] = ((opcode & XL_MASK[e*OPW +: OPW]) == XL_MATCH[e*OPW +: OPW]);
  end

  // lowest index wins: scan from the top so lower entries overwrite
  always_comb begin
    disp_addr = ILL_ADDR;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (hit[e]) disp_addr = XL_TGT[e*AW +: AW];
    end
  end
endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW         = 11,
  parameter int DW         = 22,
  parameter int BANK_WORDS = 512,
  parameter int MAX_BANKS  = 3,
  parameter logic [MAX_BANKS-1:0] BANK_MASK = '1
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word,
  output logic          missing
);
  localparam int BANK_AW = $clog2(BANK_WORDS);
  localparam int BSW     = AW - BANK_AW;
  localparam int NSLOT   = 1 << BSW;

  logic [NSLOT-1:0] fitted;
  logic [BSW-1:0]   bank_idx;
  logic [DW-1:0]    pattern;

  for (genvar b = 0; b < NSLOT; b++) begin : g_slot
    if (b < MAX_BANKS) begin : g_real
      assign fitted[b] = BANK_MASK[b];
    end else begin : g_void
      assign fitted[b] = 1'b0;
    end
  end

  assign bank_idx = addr[AW-1:BANK_AW];
  assign pattern  = DW'({addr, ~addr});

  always_comb begin
    missing = ~fitted[bank_idx];
    word    = missing ? '0 : pattern;
  end
endmodule

// File: rtl/useq_nxt.sv
module useq_nxt
  import useq_pkg::*;
#(
  parameter int AW = 11,
  parameter logic [AW-1:0] INT_VEC = '0
) (
  input  logic [AW-1:0] lc_q,
  input  logic [AW-1:0] ret_q,
  input  logic [2:0]    seq_op,
  input  logic [AW-1:0] jmp_tgt,
  input  logic [AW-1:0] disp_addr,
  input  logic          int_pend,
  input  logic          int_test,
  output logic [AW-1:0] lc_d,
  output logic          ret_we,
  output logic [AW-1:0] ret_d
);
  seq_op_e op;
  logic    take_int;

  assign op       = seq_op_e'(seq_op);
  assign take_int = int_pend & int_test;
  assign ret_d    = lc_q + AW'(1);

  always_comb begin
    lc_d   = lc_q + AW'(1);
    ret_we = 1'b0;
    if (take_int) begin
      lc_d = INT_VEC;
    end else begin
      case (op)
        SEQ_JMP:  lc_d = jmp_tgt;
        SEQ_CALL: begin
          lc_d   = jmp_tgt;
          ret_we = 1'b1;
        end
        SEQ_RET:  lc_d = ret_q;
        SEQ_DISP: lc_d = disp_addr;
        default:  lc_d = lc_q + AW'(1);
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top #(
  parameter int AW         = 11,
  parameter int DW         = 22,
  parameter int OPW        = 16,
  parameter int BANK_WORDS = 512,
  parameter int MAX_BANKS  = 3,
  parameter logic [MAX_BANKS-1:0] BANK_MASK = 3'b011,
  parameter int NENT       = 4,
  parameter logic [NENT*OPW-1:0] XL_MASK  = {16'hFF00, 16'hF000, 16'hFFC0, 16'hFFFF},
  parameter logic [NENT*OPW-1:0] XL_MATCH = {16'h0A00, 16'h1000, 16'h0A00, 16'h0000},
  parameter logic [NENT*AW-1:0]  XL_TGT   = {11'h100, 11'h0C0, 11'h080, 11'h040},
  parameter logic [AW-1:0] ILL_ADDR = 11'h7F0,
  parameter logic [AW-1:0] INT_VEC  = 11'h010
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [2:0]     seq_op,
  input  logic [AW-1:0]  jmp_tgt,
  input  logic           int_pend,
  input  logic           int_test,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  uaddr,
  output logic [DW-1:0]  uword,
  output logic           bank_missing
);
  logic          rst_s1, rst_q;
  logic [AW-1:0] lc_q, lc_d, ret_q, ret_d, disp_addr;
  logic          ret_we;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  useq_xlate #(
    .AW(AW), .OPW(OPW), .NENT(NENT), .XL_MASK(XL_MASK),
    .XL_MATCH(XL_MATCH), .XL_TGT(XL_TGT), .ILL_ADDR(ILL_ADDR)
  ) u_xlate (
    .opcode(opcode), .disp_addr(disp_addr)
  );

  useq_nxt #(.AW(AW), .INT_VEC(INT_VEC)) u_nxt (
    .lc_q(lc_q), .ret_q(ret_q), .seq_op(seq_op), .jmp_tgt(jmp_tgt),
    .disp_addr(disp_addr), .int_pend(int_pend), .int_test(int_test),
    .lc_d(lc_d), .ret_we(ret_we), .ret_d(ret_d)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lc_q  <= '0;
      ret_q <= '0;
    end else if (step) begin
      lc_q <= lc_d;
      if (ret_we) ret_q <= ret_d;
    end
  end

  useq_store #(
    .AW(AW), .DW(DW), .BANK_WORDS(BANK_WORDS),
    .MAX_BANKS(MAX_BANKS), .BANK_MASK(BANK_MASK)
  ) u_store (
    .addr(lc_q), .word(uword), .missing(bank_missing)
  );

  assign uaddr = lc_q;

  // R2
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_q)
    (step && !(int_pend && int_test) && (seq_op == 3'd0 || seq_op > 3'd4))
      |=> uaddr == $past(uaddr) + AW'(1));
  // R3
  a_r3_jump: assert property (@(posedge clk) disable iff (!rst_q)
    (step && !(int_pend && int_test) && seq_op == 3'd1) |=> uaddr == $past(jmp_tgt));
  // R4
  a_r4_call_saves: assert property (@(posedge clk) disable iff (!rst_q)
    (step && !(int_pend && int_test) && seq_op == 3'd2)
      |=> (ret_q == $past(uaddr) + AW'(1)) && (uaddr == $past(jmp_tgt)));
  // R5
  a_r5_return: assert property (@(posedge clk) disable iff (!rst_q)
    (step && !(int_pend && int_test) && seq_op == 3'd3) |=> uaddr == $past(ret_q));
  // R7
  a_r7_int_vector: assert property (@(posedge clk) disable iff (!rst_q)
    (step && int_pend && int_test) |=> (uaddr == INT_VEC) && $stable(ret_q));
  // R8
  a_r8_missing_zero: assert property (@(posedge clk) disable iff (!rst_q)
    bank_missing |-> uword == '0);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !step |=> $stable(uaddr) && $stable(ret_q));
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step;
  logic [2:0]  seq_op;
  logic [10:0] jmp_tgt;
  logic        int_pend, int_test;
  logic [15:0] opcode;
  logic [10:0] uaddr;
  logic [21:0] uword;
  logic        bank_missing;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  useq_top #(.BANK_MASK(3'b101)) u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .seq_op(seq_op), .jmp_tgt(jmp_tgt),
    .int_pend(int_pend), .int_test(int_test), .opcode(opcode),
    .uaddr(uaddr), .uword(uword), .bank_missing(bank_missing)
  );

  function automatic logic [10:0] exp_disp(input logic [15:0] op);
    if (op == 16'h0000) return 11'h040;
    if ((op & 16'hFFC0) == 16'h0A00) return 11'h080;
    if ((op & 16'hF000) == 16'h1000) return 11'h0C0;
    if ((op & 16'hFF00) == 16'h0A00) return 11'h100;
    return 11'h7F0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge act, return at the next negedge
  task automatic cyc(input logic st, input logic [2:0] op, input logic [10:0] tgt,
                     input logic ip, input logic it, input logic [15:0] opc);
    step = st; seq_op = op; jmp_tgt = tgt; int_pend = ip; int_test = it; opcode = opc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step = 1'b0; seq_op = 3'd0; jmp_tgt = '0; int_pend = 1'b0; int_test = 1'b0; opcode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset uaddr", 32'(uaddr), 32'h0);
    chk("R8 uword at 0", 32'(uword), {10'h0, 11'h000, 11'h7FF});
    cyc(1, 3'd3, 11'h0, 0, 0, 16'h0);
    chk("R1 return reg cleared", 32'(uaddr), 32'h0);

    // R8: every address through jumps
    for (int a = 0; a < 2048; a++) begin
      logic [10:0] ad;
      logic        miss;
      ad   = 11'(a);
      miss = (ad[10:9] == 2'd1) || (ad[10:9] == 2'd3);
      cyc(1, 3'd1, ad, 0, 0, 16'h0);
      chk("R3 jump", 32'(uaddr), 32'(ad));
      chk("R8 missing", 32'(bank_missing), 32'(miss));
      chk("R8 word", 32'(uword), miss ? 32'h0 : 32'({ad, ~ad}));
    end

    // R6: all opcodes
    for (int o = 0; o < 65536; o++) begin
      cyc(1, 3'd4, 11'h0, 0, 0, 16'(o));
      chk("R6 dispatch", 32'(uaddr), 32'(exp_disp(16'(o))));
    end

    // R2: increment and wrap, reserved codes
    cyc(1, 3'd1, 11'h7FD, 0, 0, 16'h0);
    cyc(1, 3'd0, 11'h0, 0, 0, 16'h0);
    chk("R2 inc", 32'(uaddr), 32'h7FE);
    cyc(1, 3'd5, 11'h0, 0, 0, 16'h0);
    chk("R2 code5", 32'(uaddr), 32'h7FF);
    cyc(1, 3'd6, 11'h0, 0, 0, 16'h0);
    chk("R2 wrap", 32'(uaddr), 32'h000);
    cyc(1, 3'd7, 11'h0, 0, 0, 16'h0);
    chk("R2 code7", 32'(uaddr), 32'h001);

    // R4/R5: call and return
    cyc(1, 3'd1, 11'h123, 0, 0, 16'h0);
    cyc(1, 3'd2, 11'h300, 0, 0, 16'h0);
    chk("R4 call target", 32'(uaddr), 32'h300);
    cyc(1, 3'd0, 11'h0, 0, 0, 16'h0);
    cyc(1, 3'd1, 11'h055, 0, 0, 16'h0);
    cyc(1, 3'd4, 11'h0, 0, 0, 16'h1234);
    cyc(1, 3'd3, 11'h0, 0, 0, 16'h0);
    chk("R5 return", 32'(uaddr), 32'h124);
    cyc(1, 3'd1, 11'h7FF, 0, 0, 16'h0);
    cyc(1, 3'd2, 11'h200, 0, 0, 16'h0);
    cyc(1, 3'd3, 11'h0, 0, 0, 16'h0);
    chk("R4 call at 7FF wraps", 32'(uaddr), 32'h000);

    // R7: interrupt
    cyc(1, 3'd1, 11'h400, 0, 0, 16'h0);
    cyc(1, 3'd2, 11'h500, 0, 0, 16'h0);
    cyc(1, 3'd2, 11'h600, 1, 1, 16'h0);
    chk("R7 vector on call", 32'(uaddr), 32'h010);
    cyc(1, 3'd3, 11'h0, 0, 0, 16'h0);
    chk("R7 ret reg kept", 32'(uaddr), 32'h401);
    cyc(1, 3'd1, 11'h222, 1, 0, 16'h0);
    chk("R7 pend only", 32'(uaddr), 32'h222);
    cyc(1, 3'd1, 11'h333, 0, 1, 16'h0);
    chk("R7 test only", 32'(uaddr), 32'h333);
    cyc(1, 3'd4, 11'h0, 1, 1, 16'h0A00);
    chk("R7 over dispatch", 32'(uaddr), 32'h010);

    // R9: hold
    cyc(1, 3'd2, 11'h444, 0, 0, 16'h0);
    cyc(0, 3'd2, 11'h666, 1, 1, 16'h0);
    chk("R9 hold counter", 32'(uaddr), 32'h444);
    cyc(0, 3'd0, 11'h0, 0, 0, 16'h0);
    chk("R9 hold inc", 32'(uaddr), 32'h444);
    cyc(1, 3'd3, 11'h0, 0, 0, 16'h0);
    chk("R9 ret reg held", 32'(uaddr), 32'h011);

    // R1: reset again from a busy state
    do_reset();
    chk("R1 second reset", 32'(uaddr), 32'h0);
    cyc(1, 3'd3, 11'h0, 0, 0, 16'h0);
    chk("R1 ret after reset", 32'(uaddr), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule